// File: doc/BRIEF.md
# Key-Protected Independent Watchdog Timer

This block is a watchdog that runs entirely on its own slow clock. Software reaches it through a small write bus with three addresses. Address 0 is a key register, address 1 holds a 3-bit prescaler code and address 2 holds a 12-bit reload value. The watchdog starts, refreshes and opens its configuration registers only when it receives specific 16-bit key values. A wrong value or a locked write does nothing. Once started, the watchdog cannot be stopped.

A prescaler divides the clock and feeds a 12-bit down-counter. When the counter is at zero on a divided tick, the block raises a one-cycle reset request and reloads itself. A configuration write is not used at once. The value sits behind an update-pending flag for a fixed number of cycles, which models the transfer into the counter's clock domain. Only after that does the counter or prescaler use the new value.

Top module: `wdg_top`

## Requirements
- R1: After synchronous reset the prescaler code is 0, the reload value is 0xFFF, the count is 0xFFF, configuration writes are locked, the counter is idle, both busy flags are clear and no reset request is raised.
- R2: Writing 0x5555 to address 0 unlocks configuration writes, and writing 0x0000 locks them again. Any other key value leaves the lock state unchanged.
- R3: A write to address 1 or address 2 while locked is ignored. The stored value and both busy flags stay as they were.
- R4: A write to address 2 keeps data bits 11:0, and a write to address 1 keeps data bits 2:0. Prescaler code c divides the clock by 4·2^c for c from 0 to 6, and code 7 divides by 256 like code 6.
- R5: An accepted write to address 1 sets busy bit 0, and one to address 2 sets busy bit 1. Each flag stays high for exactly UPD_LAT cycles. The counter logic uses the new value only when the flag clears. `ready_o` is high exactly when both flags are clear.
- R6: Writing 0xCCCC while idle starts the watchdog. The count loads the active reload value R, and the count then drops by one every divided period D.
- R7: Writing 0xAAAA while running reloads the count and restarts the prescaler. Writing it while idle has no effect.
- R8: A divided tick that finds the count at zero raises `wdg_rst_o` for one cycle and reloads the count. The request therefore comes (R+1)·D cycles after a start or refresh, and every (R+1)·D cycles after that.
- R9: Once running, no key value stops the watchdog.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Watchdog clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 2 | 0 key, 1 prescaler code, 2 reload value |
| bus_wdata | input | 16 | Write data |
| presc_o | output | 3 | Stored prescaler code |
| reload_o | output | 12 | Stored reload value |
| count_o | output | 12 | Current down-counter value |
| busy_o | output | 2 | Update pending: bit 0 prescaler, bit 1 reload |
| ready_o | output | 1 | Both update flags clear |
| unlocked_o | output | 1 | Configuration writes accepted |
| running_o | output | 1 | Watchdog started |
| wdg_rst_o | output | 1 | One-cycle reset request |

## Verification
A write on a clock edge shows up in the key state, the stored values, the busy flags and a counter load one cycle later. A busy flag falls UPD_LAT cycles after the edge that set it. The first reset request arrives (R+1)·D cycles after the start or refresh edge. The bench drives each write for one edge and samples on the falling edge that follows. A behavioural model advances on the same rising edge and is compared against every output at each falling edge. Directed checks count falling edges from a write to the fall of a busy flag, and between reset requests, and compare those counts with the figures above.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int KEY_W = 16;
  localparam logic [KEY_W-1:0] KEY_START  = 16'hCCCC;
  localparam logic [KEY_W-1:0] KEY_KICK   = 16'hAAAA;
  localparam logic [KEY_W-1:0] KEY_OPEN   = 16'h5555;
  localparam logic [KEY_W-1:0] KEY_CLOSE  = 16'h0000;

  typedef enum logic [1:0] {
    A_KEY   = 2'd0,
    A_PSC   = 2'd1,
    A_RLD   = 2'd2,
    A_SPARE = 2'd3
  } wdg_addr_e;
endpackage

// File: rtl/wdg_keydec.sv
module wdg_keydec
  import wdg_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [1:0]       addr,
  input  logic [KEY_W-1:0] wdata,
  output logic             start_k,
  output logic             kick_k,
  output logic             unlocked
);
  logic key_wr;
  assign key_wr  = we && (addr == A_KEY);
  assign start_k = key_wr && (wdata == KEY_START);
  assign kick_k  = key_wr && (wdata == KEY_KICK);

  always_ff @(posedge clk) begin
    if (rst) begin
      unlocked <= 1'b0;
    end else if (key_wr && (wdata == KEY_OPEN)) begin
      unlocked <= 1'b1;
    end else if (key_wr && (wdata == KEY_CLOSE)) begin
      unlocked <= 1'b0;
    end
  end
endmodule

// File: rtl/wdg_cfg_field.sv
// One configuration field: the stored value updates on the write edge, and
// the active value follows LAT cycles later while the pending flag is high.
module wdg_cfg_field #(
  parameter int          W       = 12,
  parameter int          LAT     = 5,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] stored,
  output logic [W-1:0] active,
  output logic         pending
);
  localparam int TW = $clog2(LAT + 1);
  localparam logic [TW-1:0] LAT_V = TW'(LAT);
  localparam logic [TW-1:0] ONE_V = TW'(1);

  logic [TW-1:0] tmr;

  always_ff @(posedge clk) begin
    if (rst) begin
      stored <= RST_VAL;
      active <= RST_VAL;
      tmr    <= '0;
    end else if (wr) begin
      stored <= wdata;
      tmr    <= LAT_V;
    end else if (tmr != '0) begin
      tmr <= tmr - ONE_V;
      if (tmr == ONE_V) active <= stored;
    end
  end

  assign pending = (tmr != '0);
endmodule

// File: rtl/wdg_presc.sv
module wdg_presc #(
  parameter int PSC_W     = 3,
  parameter int MIN_SHIFT = 2,
  parameter int CODE_MAX  = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             restart,
  input  logic [PSC_W-1:0] code,
  output logic             tick
);
  localparam int DW = MIN_SHIFT + CODE_MAX + 1;
  localparam logic [PSC_W-1:0] CMAX = PSC_W'(CODE_MAX);
  localparam logic [DW-1:0]    ONE  = DW'(1);

  logic [DW-1:0]    pcnt;
  logic [PSC_W-1:0] eff;
  logic [DW-1:0]    lim;

  assign eff  = (code > CMAX) ? CMAX : code;
  assign lim  = (ONE << (MIN_SHIFT + 32'(eff))) - ONE;
  assign tick = run && !restart && (pcnt >= lim);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      pcnt <= '0;
    end else if (run) begin
      pcnt <= tick ? '0 : pcnt + ONE;
    end
  end
endmodule

// File: rtl/wdg_counter.sv
module wdg_counter #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             tick,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] count,
  output logic             running,
  output logic             req
);
  always_ff @(posedge clk) begin
    if (rst) begin
      count   <= '1;
      running <= 1'b0;
      req     <= 1'b0;
    end else begin
      req <= 1'b0;
      if (load) begin
        count   <= reload;
        running <= 1'b1;
      end else if (tick) begin
        if (count == '0) begin
          req   <= 1'b1;
          count <= reload;
        end else begin
          count <= count - CNT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/wdg_top.sv
module wdg_top
  import wdg_pkg::*;
#(
  parameter int CNT_W     = 12,
  parameter int PSC_W     = 3,
  parameter int UPD_LAT   = 5,
  parameter int MIN_SHIFT = 2,
  parameter int CODE_MAX  = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_we,
  input  logic [1:0]       bus_addr,
  input  logic [15:0]      bus_wdata,
  output logic [PSC_W-1:0] presc_o,
  output logic [CNT_W-1:0] reload_o,
  output logic [CNT_W-1:0] count_o,
  output logic [1:0]       busy_o,
  output logic             ready_o,
  output logic             unlocked_o,
  output logic             running_o,
  output logic             wdg_rst_o
);
  logic             start_k, kick_k, unl;
  logic [PSC_W-1:0] psc_act;
  logic [CNT_W-1:0] rld_act;
  logic             load, tick;

  wdg_keydec u_key (
    .clk(clk), .rst(rst), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
    .start_k(start_k), .kick_k(kick_k), .unlocked(unl)
  );

  wdg_cfg_field #(.W(PSC_W), .LAT(UPD_LAT), .RST_VAL('0)) u_psc (
    .clk(clk), .rst(rst),
    .wr(bus_we && (bus_addr == A_PSC) && unl),
    .wdata(bus_wdata[PSC_W-1:0]),
    .stored(presc_o), .active(psc_act), .pending(busy_o[0])
  );

  wdg_cfg_field #(.W(CNT_W), .LAT(UPD_LAT), .RST_VAL('1)) u_rld (
    .clk(clk), .rst(rst),
    .wr(bus_we && (bus_addr == A_RLD) && unl),
    .wdata(bus_wdata[CNT_W-1:0]),
    .stored(reload_o), .active(rld_act), .pending(busy_o[1])
  );

  assign load = (start_k && !running_o) || (kick_k && running_o);

  wdg_presc #(.PSC_W(PSC_W), .MIN_SHIFT(MIN_SHIFT), .CODE_MAX(CODE_MAX)) u_div (
    .clk(clk), .rst(rst), .run(running_o), .restart(load),
    .code(psc_act), .tick(tick)
  );

  wdg_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .load(load), .tick(tick), .reload(rld_act),
    .count(count_o), .running(running_o), .req(wdg_rst_o)
  );

  assign ready_o    = ~|busy_o;
  assign unlocked_o = unl;
endmodule

// File: rtl/wdg_checker.sv
module wdg_checker #(
  parameter int CNT_W = 12,
  parameter int PSC_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             bus_we,
  input logic [1:0]       bus_addr,
  input logic [15:0]      bus_wdata,
  input logic [PSC_W-1:0] presc_o,
  input logic [CNT_W-1:0] count_o,
  input logic [1:0]       busy_o,
  input logic             unlocked_o,
  input logic             running_o,
  input logic             wdg_rst_o
);
  AST_UNLOCK_KEY: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == 2'd0 && bus_wdata == 16'h5555) |=> unlocked_o); // R2
  AST_LOCKED_PSC_HOLD: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == 2'd1 && !unlocked_o) |=> ($stable(presc_o) && !$rose(busy_o[0]))); // R3
  AST_REQ_FROM_ZERO: assert property (@(posedge clk) disable iff (rst)
    $rose(wdg_rst_o) |-> ($past(count_o) == '0)); // R8
  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
    wdg_rst_o |=> !wdg_rst_o); // R8
  AST_RUN_STICKY: assert property (@(posedge clk) disable iff (rst)
    running_o |=> running_o); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !running_o |-> !wdg_rst_o); // R6
endmodule

bind wdg_top wdg_checker #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_chk (
  .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .presc_o(presc_o), .count_o(count_o),
  .busy_o(busy_o), .unlocked_o(unlocked_o), .running_o(running_o),
  .wdg_rst_o(wdg_rst_o)
);

// File: tb/wdg_top_test.sv
`timescale 1ns/1ps
module wdg_top_test;
  localparam int LAT = 5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_we = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [15:0] bus_wdata = 16'h0;
  logic [2:0]  presc_o;
  logic [11:0] reload_o, count_o;
  logic [1:0]  busy_o;
  logic        ready_o, unlocked_o, running_o, wdg_rst_o;

  int vectors = 0;
  int fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  wdg_top #(.UPD_LAT(LAT)) uut (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .presc_o(presc_o), .reload_o(reload_o),
    .count_o(count_o), .busy_o(busy_o), .ready_o(ready_o),
    .unlocked_o(unlocked_o), .running_o(running_o), .wdg_rst_o(wdg_rst_o)
  );

  task automatic check(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int m_run, m_unl, m_pst, m_pact, m_ptmr, m_rst, m_ract, m_rtmr;
  int m_cnt, m_pcnt, m_req;

  always @(posedge clk) begin
    int n_run, n_unl, n_pst, n_pact, n_ptmr, n_rst, n_ract, n_rtmr;
    int n_cnt, n_pcnt, n_req, d, div, code;
    bit key, load;
    if (rst) begin
      m_run = 0; m_unl = 0; m_pst = 0; m_pact = 0; m_ptmr = 0;
      m_rst = 4095; m_ract = 4095; m_rtmr = 0; m_cnt = 4095; m_pcnt = 0; m_req = 0;
    end else begin
      n_run = m_run; n_unl = m_unl; n_pst = m_pst; n_pact = m_pact; n_ptmr = m_ptmr;
      n_rst = m_rst; n_ract = m_ract; n_rtmr = m_rtmr; n_cnt = m_cnt; n_pcnt = m_pcnt;
      n_req = 0;
      d = int'(bus_wdata);
      key = bus_we && bus_addr == 2'd0;
      if (key && d == 'h5555) n_unl = 1;
      if (key && d == 0) n_unl = 0;
      if (bus_we && bus_addr == 2'd1 && m_unl != 0) begin
        n_pst = d % 8; n_ptmr = LAT;
      end else if (m_ptmr > 0) begin
        n_ptmr = m_ptmr - 1;
        if (m_ptmr == 1) n_pact = m_pst;
      end
      if (bus_we && bus_addr == 2'd2 && m_unl != 0) begin
        n_rst = d % 4096; n_rtmr = LAT;
      end else if (m_rtmr > 0) begin
        n_rtmr = m_rtmr - 1;
        if (m_rtmr == 1) n_ract = m_rst;
      end
      load = key && ((d == 'hCCCC && m_run == 0) || (d == 'hAAAA && m_run != 0));
      if (load) begin
        n_run = 1; n_cnt = m_ract; n_pcnt = 0;
      end else if (m_run != 0) begin
        code = (m_pact > 6) ? 6 : m_pact;
        div = 4 << code;
        if (m_pcnt >= div - 1) begin
          n_pcnt = 0;
          if (m_cnt == 0) begin n_req = 1; n_cnt = m_ract; end
          else n_cnt = m_cnt - 1;
        end else n_pcnt = m_pcnt + 1;
      end
      m_run = n_run; m_unl = n_unl; m_pst = n_pst; m_pact = n_pact; m_ptmr = n_ptmr;
      m_rst = n_rst; m_ract = n_ract; m_rtmr = n_rtmr; m_cnt = n_cnt; m_pcnt = n_pcnt;
      m_req = n_req;
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      check("R2 model unlocked", int'(unlocked_o), m_unl);
      check("R4 model presc", int'(presc_o), m_pst);
      check("R4 model reload", int'(reload_o), m_rst);
      check("R5 model busy", int'(busy_o), (m_ptmr > 0 ? 1 : 0) + (m_rtmr > 0 ? 2 : 0));
      check("R5 model ready", int'(ready_o), (m_ptmr == 0 && m_rtmr == 0) ? 1 : 0);
      check("R6 model count", int'(count_o), m_cnt);
      check("R9 model running", int'(running_o), m_run);
      check("R8 model request", int'(wdg_rst_o), m_req);
    end
  end

  task automatic wr(input logic [1:0] a, input logic [15:0] v);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = v;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = 16'h0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_req(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!wdg_rst_o && n < 5000);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    idle(2);
    rst = 1'b0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete, got 0 expected 1");
    finish_run();
  end

  initial begin
    int n;
    idle(3);
    // R1 reset values
    check("R1 presc", int'(presc_o), 0);
    check("R1 reload", int'(reload_o), 4095);
    check("R1 count", int'(count_o), 4095);
    check("R1 locked", int'(unlocked_o), 0);
    check("R1 idle", int'(running_o), 0);
    check("R1 busy", int'(busy_o), 0);
    check("R1 request", int'(wdg_rst_o), 0);
    rst = 1'b0;
    idle(1);

    // R3 locked writes dropped
    wr(2'd1, 16'h0003);
    check("R3 presc locked", int'(presc_o), 0);
    check("R3 busy locked", int'(busy_o), 0);
    wr(2'd2, 16'h0010);
    check("R3 reload locked", int'(reload_o), 4095);

    // R2 unlock and stray key
    wr(2'd0, 16'h5555);
    check("R2 unlocked", int'(unlocked_o), 1);
    wr(2'd0, 16'h1234);
    check("R2 stray key", int'(unlocked_o), 1);

    // R4 masking, R5 busy timing
    wr(2'd1, 16'hFFF9);
    check("R4 presc mask", int'(presc_o), 1);
    check("R5 busy psc", int'(busy_o), 1);
    check("R5 ready low", int'(ready_o), 0);
    n = 0;
    while (busy_o[0] && n < 100) begin @(negedge clk); n++; end
    check("R5 busy length", n, LAT);
    wr(2'd2, 16'hF003);
    check("R4 reload mask", int'(reload_o), 3);
    check("R5 busy rld", int'(busy_o), 2);
    idle(LAT + 1);
    check("R5 ready high", int'(ready_o), 1);

    // R2 lock, R3 ignored after lock
    wr(2'd0, 16'h0000);
    check("R2 locked", int'(unlocked_o), 0);
    wr(2'd2, 16'h0007);
    check("R3 reload relocked", int'(reload_o), 3);
    check("R3 busy relocked", int'(busy_o), 0);

    // R6 start, R8 period (3+1)*8
    wr(2'd0, 16'hCCCC);
    check("R6 running", int'(running_o), 1);
    check("R6 count loaded", int'(count_o), 3);
    wait_req(n);
    check("R8 first request", n, 32);
    @(negedge clk);
    check("R8 single cycle", int'(wdg_rst_o), 0);
    check("R8 reloaded", int'(count_o), 3);

    // R7 refresh
    idle(20);
    wr(2'd0, 16'hAAAA);
    check("R7 refresh count", int'(count_o), 3);
    wait_req(n);
    check("R7 request after refresh", n, 32);

    // R9 no stop
    wr(2'd0, 16'h0000);
    wr(2'd0, 16'hCCCC);
    wr(2'd0, 16'hBEEF);
    check("R9 still running", int'(running_o), 1);

    // R4 code 7 acts like 256, reload 0
    wr(2'd0, 16'h5555);
    wr(2'd1, 16'h0007);
    wr(2'd2, 16'hA000);
    check("R4 reload zero", int'(reload_o), 0);
    idle(LAT + 1);
    wait_req(n);
    wait_req(n);
    wait_req(n);
    check("R4 code 7 period", n, 256);

    // R7 refresh while idle ignored
    do_reset();
    wr(2'd0, 16'hAAAA);
    check("R7 idle refresh count", int'(count_o), 4095);
    check("R7 idle refresh run", int'(running_o), 0);
    idle(4);
    finish_run();
  end
endmodule